// File: doc/BRIEF.md
# DMA Tag Group Completion Tracker

This block follows the completion of queued DMA commands by their 5-bit tag and reports group status to software through a small set of channels. A command channel write carries a tag and enqueues one command in a 16-entry queue. The block keeps the number of free queue slots, which software reads as the command channel count. For every tag it also keeps a count of outstanding commands. Completion strobes from the transfer engine release one slot and lower the outstanding count of the strobed tag.

On the status side, software writes a 32-bit query mask with one bit per tag group. It then posts an update request that selects when the status becomes readable: at once, when any queried group has drained, or when every queried group has drained. The request channel holds at most one request, and the status channel holds at most one result. Reading the result consumes it and opens the request channel again. The tracker does not move data or translate addresses.

Top module: `tag_done_tracker`

## Requirements
- R1: After reset, the free-slot count is 16, the request channel count is 1, the status channel count is 0, the status word is 0 and the query mask is 0.
- R2: A command write with a nonzero free-slot count is accepted and lowers the count by one in the next cycle. A command write at count 0 is not accepted and the count stays 0.
- R3: An accepted completion strobe raises the free-slot count by one and lowers the outstanding count of its tag. An enqueue and an accepted completion in the same cycle leave the free-slot count unchanged.
- R4: A completion strobe for a tag with no outstanding commands is ignored and leaves the free-slot count unchanged.
- R5: A write to the query mask is always taken, never stalls, and is used from the next cycle on. This includes a write made while a request is waiting.
- R6: An update request is accepted only while the request channel count is 1, and the count drops to 0. A request written while the count is 0 is ignored.
- R7: Mode value 0 (and the unused value 3) makes the result available one cycle after the request is accepted.
- R8: Mode value 1 holds the result back until at least one queried group has no outstanding commands. With an empty mask it never fires.
- R9: Mode value 2 holds the result back until every queried group has no outstanding commands. With an empty mask it fires one cycle after acceptance.
- R10: A status read while the status count is 1 returns the latched word, sets the status count to 0 and the request count to 1. A read while the status count is 0 has no effect.
- R11: In the latched status word, bit t is 1 exactly when tag t is in the mask and has no outstanding commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command channel write |
| cmd_tag | input | 5 | Tag of the written command |
| cmd_free | output | 5 | Free queue slots (command channel count) |
| cpl_valid | input | 1 | Completion strobe from the transfer engine |
| cpl_tag | input | 5 | Tag of the completed command |
| mask_valid | input | 1 | Query mask write |
| mask_data | input | 32 | Query mask, one bit per tag group |
| req_valid | input | 1 | Update request write |
| req_mode | input | 2 | Update mode: 0 now, 1 any, 2 all |
| req_cnt | output | 1 | Request channel count |
| rd_valid | input | 1 | Status channel read |
| rd_cnt | output | 1 | Status channel count |
| rd_data | output | 32 | Latched status word |

## Verification
The hardest case to reach is a waiting request that is released by a change other than the one it was posted against. Examples are a mask rewritten while an any-mode request sits on an empty mask, and an all-mode request whose last busy group drains in the same cycle that a new command enqueues on another tag. The stimulus builds these on purpose. It loads a group with two commands and retires them one at a time, checking that the status count stays 0 in between. It then parks an any-mode request on an empty mask and rewrites the mask to release it. It finishes by filling the queue to zero slots to check the stall.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

    localparam int TAG_W    = 5;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int QDEPTH   = 16;
    localparam int CNT_W    = $clog2(QDEPTH + 1);

    typedef enum logic [1:0] {
        UPD_NOW  = 2'd0,
        UPD_ANY  = 2'd1,
        UPD_ALL  = 2'd2,
        UPD_RSVD = 2'd3
    } upd_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_READY = 2'd2
    } chan_state_e;

    typedef struct packed {
        chan_state_e st;
        upd_mode_e   mode;
    } chan_ctx_t;

    // Decide whether a waiting request may release its result.
    function automatic logic mode_fires(upd_mode_e m, logic any_done, logic all_done);
        case (m)
            UPD_ANY: return any_done;
            UPD_ALL: return all_done;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tdt_slot_counter.sv
module tdt_slot_counter #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] free_cnt,
    output logic             has_room
);
    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= FULL_FREE;
        end else begin
            case ({take, give})
                2'b10:   free_q <= free_q - 1'b1;
                2'b01:   free_q <= free_q + 1'b1;
                default: free_q <= free_q;
            endcase
        end
    end

    assign free_cnt = free_q;
    assign has_room = (free_q != '0);

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= FULL_FREE);                                          // R2
    AST_TAKE_LOWERS: assert property (@(posedge clk) disable iff (rst)
        take && !give |=> free_cnt == $past(free_cnt) - 1'b1);           // R2
    AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        take && give |=> $stable(free_cnt));                             // R3

endmodule

// File: rtl/tdt_tag_counters.sv
module tdt_tag_counters #(
    parameter int TAG_W    = 5,
    parameter int NUM_TAGS = 1 << TAG_W,
    parameter int DEPTH    = 16,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                inc_valid,
    input  logic [TAG_W-1:0]    inc_tag,
    input  logic                dec_valid,
    input  logic [TAG_W-1:0]    dec_tag,
    output logic [NUM_TAGS-1:0] idle_vec
);
    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        logic [CNT_W-1:0] pend_q;
        logic             up;
        logic             down;

        assign up   = inc_valid && (inc_tag == TAG_W'(t));
        assign down = dec_valid && (dec_tag == TAG_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= '0;
            end else if (up && !down) begin
                pend_q <= pend_q + 1'b1;
            end else if (down && !up) begin
                pend_q <= pend_q - 1'b1;
            end
        end

        assign idle_vec[t] = (pend_q == '0);

        AST_TAG_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
            down && !up |-> pend_q != '0);                               // R4
        AST_TAG_BOUND: assert property (@(posedge clk) disable iff (rst)
            pend_q <= CNT_W'(DEPTH));                                    // R3
    end

endmodule

// File: rtl/tdt_status_channel.sv
module tdt_status_channel
    import tdt_pkg::*;
#(
    parameter int NUM_TAGS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mask_we,
    input  logic [NUM_TAGS-1:0] mask_wdata,
    input  logic                req_we,
    input  logic [1:0]          req_mode,
    input  logic                rd_en,
    input  logic [NUM_TAGS-1:0] idle_vec,
    output logic                req_cnt,
    output logic                stat_cnt,
    output logic [NUM_TAGS-1:0] stat_data
);
    chan_ctx_t           ctx_q;
    logic [NUM_TAGS-1:0] mask_q;
    logic [NUM_TAGS-1:0] stat_q;
    logic [NUM_TAGS-1:0] done_vec;
    logic                any_done;
    logic                all_done;
    logic                fire;

    assign done_vec = mask_q & idle_vec;
    assign any_done = |done_vec;
    assign all_done = (done_vec == mask_q);
    assign fire     = (ctx_q.st == CH_ARMED) && mode_fires(ctx_q.mode, any_done, all_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{st: CH_IDLE, mode: UPD_NOW};
            stat_q <= '0;
        end else begin
            case (ctx_q.st)
                CH_IDLE: begin
                    if (req_we) begin
                        ctx_q.st   <= CH_ARMED;
                        ctx_q.mode <= upd_mode_e'(req_mode);
                    end
                end
                CH_ARMED: begin
                    if (fire) begin
                        ctx_q.st <= CH_READY;
                        stat_q   <= done_vec;
                    end
                end
                CH_READY: begin
                    if (rd_en) begin
                        ctx_q.st <= CH_IDLE;
                    end
                end
                default: ctx_q.st <= CH_IDLE;
            endcase
        end
    end

    assign req_cnt   = (ctx_q.st == CH_IDLE);
    assign stat_cnt  = (ctx_q.st == CH_READY);
    assign stat_data = stat_q;

    AST_COUNTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(req_cnt && stat_cnt));                                         // R10
    AST_READ_RESTORES: assert property (@(posedge clk) disable iff (rst)
        rd_en && stat_cnt |=> req_cnt && !stat_cnt);                     // R10
    AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        req_we && req_cnt |=> !req_cnt);                                 // R6
    AST_STATUS_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_cnt) |-> (stat_data & ~$past(mask_q)) == '0);         // R11
    AST_ALL_COVERS_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_cnt) && $past(ctx_q.mode) == UPD_ALL |-> stat_data == $past(mask_q)); // R9

endmodule

// File: rtl/tag_done_tracker.sv
module tag_done_tracker
    import tdt_pkg::*;
#(
    parameter int TRK_TAG_W  = tdt_pkg::TAG_W,
    parameter int TRK_DEPTH  = tdt_pkg::QDEPTH,
    localparam int TRK_TAGS  = 1 << TRK_TAG_W,
    localparam int TRK_CNT_W = $clog2(TRK_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [TRK_TAG_W-1:0] cmd_tag,
    output logic [TRK_CNT_W-1:0] cmd_free,
    input  logic                 cpl_valid,
    input  logic [TRK_TAG_W-1:0] cpl_tag,
    input  logic                 mask_valid,
    input  logic [TRK_TAGS-1:0]  mask_data,
    input  logic                 req_valid,
    input  logic [1:0]           req_mode,
    output logic                 req_cnt,
    input  logic                 rd_valid,
    output logic                 rd_cnt,
    output logic [TRK_TAGS-1:0]  rd_data
);
    logic                has_room;
    logic                enq;
    logic                cpl_ok;
    logic [TRK_TAGS-1:0] idle_vec;

    assign enq    = cmd_valid && has_room;
    assign cpl_ok = cpl_valid && !idle_vec[cpl_tag];

    tdt_slot_counter #(
        .DEPTH (TRK_DEPTH),
        .CNT_W (TRK_CNT_W)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .take     (enq),
        .give     (cpl_ok),
        .free_cnt (cmd_free),
        .has_room (has_room)
    );

    tdt_tag_counters #(
        .TAG_W    (TRK_TAG_W),
        .NUM_TAGS (TRK_TAGS),
        .DEPTH    (TRK_DEPTH),
        .CNT_W    (TRK_CNT_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .inc_valid (enq),
        .inc_tag   (cmd_tag),
        .dec_valid (cpl_ok),
        .dec_tag   (cpl_tag),
        .idle_vec  (idle_vec)
    );

    tdt_status_channel #(
        .NUM_TAGS (TRK_TAGS)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_valid),
        .mask_wdata (mask_data),
        .req_we     (req_valid),
        .req_mode   (req_mode),
        .rd_en      (rd_valid),
        .idle_vec   (idle_vec),
        .req_cnt    (req_cnt),
        .stat_cnt   (rd_cnt),
        .stat_data  (rd_data)
    );

    AST_STALL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_free == '0 && !cpl_ok |=> cmd_free == '0);      // R2
    AST_IDLE_CPL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && idle_vec[cpl_tag] && !cmd_valid |=> $stable(cmd_free)); // R4

endmodule

// File: tb/tag_done_tracker_test.sv
module tag_done_tracker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [4:0]  cmd_tag;
    logic [4:0]  cmd_free;
    logic        cpl_valid;
    logic [4:0]  cpl_tag;
    logic        mask_valid;
    logic [31:0] mask_data;
    logic        req_valid;
    logic [1:0]  req_mode;
    logic        req_cnt;
    logic        rd_valid;
    logic        rd_cnt;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    tag_done_tracker uut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_tag    (cmd_tag),
        .cmd_free   (cmd_free),
        .cpl_valid  (cpl_valid),
        .cpl_tag    (cpl_tag),
        .mask_valid (mask_valid),
        .mask_data  (mask_data),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_cnt    (req_cnt),
        .rd_valid   (rd_valid),
        .rd_cnt     (rd_cnt),
        .rd_data    (rd_data)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enqueue(logic [4:0] t);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_tag = t;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic complete(logic [4:0] t);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = t;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic enq_and_cpl(logic [4:0] et, logic [4:0] ct);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_tag = et;
        cpl_valid = 1'b1; cpl_tag = ct;
        @(negedge clk);
        cmd_valid = 1'b0; cpl_valid = 1'b0;
    endtask

    task automatic set_mask(logic [31:0] m);
        @(negedge clk);
        mask_valid = 1'b1; mask_data = m;
        @(negedge clk);
        mask_valid = 1'b0;
    endtask

    task automatic request(logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Driver side of the scoreboard: queue the expected word, then read.
    task automatic read_status(logic [31:0] expected);
        exp_q.push_back(expected);
        @(negedge clk);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Monitor: on every accepted read, compare against the queue head.
    always @(negedge clk) begin
        #5;
        if (!rst && rd_valid && rd_cnt) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected read of %0h, expected none", rd_data);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL R11: status actual %0h expected %0h", rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_tag = '0;
        cpl_valid = 1'b0; cpl_tag = '0;
        mask_valid = 1'b0; mask_data = '0;
        req_valid = 1'b0; req_mode = '0;
        rd_valid = 1'b0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 free", cmd_free, 16);
        chk("R1 req_cnt", req_cnt, 1);
        chk("R1 rd_cnt", rd_cnt, 0);
        chk("R1 rd_data", rd_data, 0);

        // R2 enqueue
        enqueue(5'd3); enqueue(5'd3); enqueue(5'd7);
        chk("R2 free after 3 enq", cmd_free, 13);

        // R7 immediate mode, R11 status content, R5 mask
        set_mask(32'h0000_0288);
        request(2'd0);
        chk("R6 req_cnt drops", req_cnt, 0);
        chk("R7 not yet ready", rd_cnt, 0);
        idle(1);
        chk("R7 ready", rd_cnt, 1);
        read_status(32'h0000_0200);
        chk("R10 rd_cnt cleared", rd_cnt, 0);
        chk("R10 req_cnt restored", req_cnt, 1);

        // R10 read with nothing pending
        read_status(32'hDEAD_BEEF);
        chk("R10 empty read rd_cnt", rd_cnt, 0);
        chk("R10 empty read req_cnt", req_cnt, 1);
        void'(exp_q.pop_back());

        // R8 any mode
        set_mask(32'h0000_0088);
        request(2'd1);
        idle(3);
        chk("R8 any waits", rd_cnt, 0);
        request(2'd0);
        idle(2);
        chk("R6 second request ignored", rd_cnt, 0);
        chk("R6 req_cnt stays 0", req_cnt, 0);
        complete(5'd7);
        chk("R3 free after cpl", cmd_free, 14);
        idle(1);
        chk("R8 any fires", rd_cnt, 1);
        read_status(32'h0000_0080);

        // R9 all mode with tag 3 holding two commands
        request(2'd2);
        complete(5'd3);
        idle(1);
        chk("R9 all waits on one busy", rd_cnt, 0);
        chk("R3 free after tag3 cpl", cmd_free, 15);
        enq_and_cpl(5'd12, 5'd3);
        chk("R3 same-cycle free held", cmd_free, 15);
        idle(1);
        chk("R9 all fires", rd_cnt, 1);
        read_status(32'h0000_0088);

        // R4 completion on idle tag
        complete(5'd20);
        chk("R4 idle cpl ignored", cmd_free, 15);

        // R9 empty mask, R8 empty mask, R5 mask write while waiting
        set_mask(32'h0);
        request(2'd2);
        idle(1);
        chk("R9 empty mask fires", rd_cnt, 1);
        read_status(32'h0);
        request(2'd1);
        idle(4);
        chk("R8 empty mask never fires", rd_cnt, 0);
        set_mask(32'h0000_0020);
        idle(1);
        chk("R5 mask write releases", rd_cnt, 1);
        read_status(32'h0000_0020);

        // R2 fill queue and stall
        for (int i = 0; i < 15; i++) enqueue(5'd1);
        chk("R2 queue full", cmd_free, 0);
        enqueue(5'd2);
        chk("R2 stall at zero", cmd_free, 0);
        complete(5'd2);
        chk("R4 stalled tag not counted", cmd_free, 0);
        complete(5'd12);
        chk("R3 slot released", cmd_free, 1);

        idle(2);
        chk("R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule